// File: doc/BRIEF.md
# Host to Sub-CPU Byte Mailbox

This block passes single bytes in both directions between a host CPU bus and a smaller interface processor. On the host side it presents a byte-wide data register and a read-only status register at two neighbouring addresses of a small window. A host write to the data register hands a byte to the sub processor. A host read of the data register takes the byte the sub processor left there. The sub processor has its own read strobe, write strobe and data lines, and an interrupt that tells it a byte is waiting.

Three flags drive the handshake. An outbound-full flag means a byte waits for the host. An inbound-full flag means a byte waits for the sub processor. A fetch-idle flag is high unless the sub processor is in the middle of a read. The host may write only while fetch-idle is high and inbound-full is low, so it cannot overwrite the byte the sub processor is collecting. All strobes are sampled on `clk_i`. A host or sub write takes effect on the first clock its strobe is seen high. The side effects of a read happen on the clock its strobe is first seen low again.

Top module: `byte_mailbox`

## Requirements
- R1: A host read at status offset 0xF returns the outbound-full flag on bit 0, the inbound-full flag on bit 1, the fetch-idle flag on bit 2, and 0 on bits 7 to 3.
- R2: A host write strobe at data offset 0xE, taken while fetch-idle is 1 and inbound-full is 0, places the byte on `sub_rdata_o` and sets inbound-full on the next clock.
- R3: A host write at 0xE taken while fetch-idle is 0 or inbound-full is 1 is ignored: `sub_rdata_o` and the flags keep their values.
- R4: Fetch-idle reads 0 from the clock after `sub_rd_i` is seen high until its strobe ends.
- R5: On the clock that `sub_rd_i` is first seen low after being high, inbound-full clears and fetch-idle returns to 1.
- R6: A rising `sub_wr_i` latches `sub_wdata_i` as the outbound byte and sets outbound-full. A host read at 0xE returns that byte.
- R7: When a host read strobe at 0xE ends, outbound-full clears.
- R8: A host read at 0xE while outbound-full is 0 returns the last outbound byte and leaves all flags unchanged.
- R9: Reset clears both data bytes, outbound-full and inbound-full, and sets fetch-idle, so status reads 0x04.
- R10: `sub_irq_o` follows inbound-full and `host_irq_o` follows outbound-full.
- R11: A host read at any offset other than 0xE and 0xF returns 0. A host write to 0xF, or a write strobe with `host_cs_i` low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_i | input | 1 | Host chip select, active high |
| host_rd_i | input | 1 | Host read strobe, active high |
| host_wr_i | input | 1 | Host write strobe, active high |
| host_addr_i | input | 4 | Host byte offset within the window |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, 0 when no read is selected |
| host_irq_o | output | 1 | A byte waits for the host |
| sub_rd_i | input | 1 | Sub processor read strobe |
| sub_wr_i | input | 1 | Sub processor write strobe |
| sub_wdata_i | input | 8 | Sub processor write data |
| sub_rdata_o | output | 8 | Inbound byte for the sub processor |
| sub_irq_o | output | 1 | A byte waits for the sub processor |

## Verification
The assertions assume that `host_addr_i` and `host_cs_i` stay constant for as long as a host strobe is high. They also assume that a host write strobe never starts on the same clock as a sub read strobe, because that race is exactly the one the fetch-idle flag is there to guard. The bench holds every strobe for one whole clock, changes the address only while the strobes are low, and starts host writes during a sub read only after the fetch-idle flag has already dropped. That way the blocked-write path is exercised without reaching the same-edge race.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OUT_FULL_BIT = 0;
  localparam int unsigned IN_FULL_BIT  = 1;
  localparam int unsigned IDLE_BIT     = 2;
  localparam int unsigned FLAG_CNT     = 3;
endpackage

// File: rtl/mbx_edge.sv
module mbx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= lvl_i;
  end
  assign q_o    = q;
  assign rise_o = lvl_i & ~q;
  assign fall_o = ~lvl_i & q;
endmodule

// File: rtl/mbx_host_dec.sv
module mbx_host_dec #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hE,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'hF
) (
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] out_byte_i,
  input  logic              out_full_i,
  input  logic              in_full_i,
  input  logic              idle_i,
  output logic              data_wr_lvl_o,
  output logic              data_rd_lvl_o,
  output logic [DATA_W-1:0] rdata_o
);
  import mbx_pkg::*;

  logic sel_data, sel_stat;
  logic [DATA_W-1:0] stat;

  assign sel_data      = cs_i & (addr_i == DATA_OFS);
  assign sel_stat      = cs_i & (addr_i == STAT_OFS);
  assign data_wr_lvl_o = sel_data & wr_i;
  assign data_rd_lvl_o = sel_data & rd_i;

  always_comb begin
    stat               = '0;
    stat[OUT_FULL_BIT] = out_full_i;
    stat[IN_FULL_BIT]  = in_full_i;
    stat[IDLE_BIT]     = idle_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_data)      rdata_o = out_byte_i;
      else if (sel_stat) rdata_o = stat;
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_rise_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_fall_i,
  input  logic              sub_wr_rise_i,
  input  logic [DATA_W-1:0] sub_wdata_i,
  input  logic              sub_rd_lvl_i,
  input  logic              sub_rd_fall_i,
  output logic [DATA_W-1:0] in_byte_o,
  output logic [DATA_W-1:0] out_byte_o,
  output logic              in_full_o,
  output logic              out_full_o,
  output logic              idle_o
);
  logic [DATA_W-1:0] in_q, out_q;
  logic in_full_q, out_full_q, idle_q;
  logic host_wr_ok;

  // host may only load while the sub side is idle and the slot is empty
  assign host_wr_ok = host_wr_rise_i & idle_q & ~in_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q       <= '0;
      out_q      <= '0;
      in_full_q  <= 1'b0;
      out_full_q <= 1'b0;
      idle_q     <= 1'b1;
    end else begin
      idle_q <= ~sub_rd_lvl_i;
      if (host_wr_ok) begin
        in_q      <= host_wdata_i;
        in_full_q <= 1'b1;
      end else if (sub_rd_fall_i) begin
        in_full_q <= 1'b0;
      end
      if (sub_wr_rise_i) begin
        out_q      <= sub_wdata_i;
        out_full_q <= 1'b1;
      end else if (host_rd_fall_i) begin
        out_full_q <= 1'b0;
      end
    end
  end

  assign in_byte_o  = in_q;
  assign out_byte_o = out_q;
  assign in_full_o  = in_full_q;
  assign out_full_o = out_full_q;
  assign idle_o     = idle_q;
endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hE,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_irq_o,
  input  logic              sub_rd_i,
  input  logic              sub_wr_i,
  input  logic [DATA_W-1:0] sub_wdata_i,
  output logic [DATA_W-1:0] sub_rdata_o,
  output logic              sub_irq_o
);
  localparam int unsigned N_STB = 4;
  localparam int unsigned S_HWR = 0;
  localparam int unsigned S_HRD = 1;
  localparam int unsigned S_SWR = 2;
  localparam int unsigned S_SRD = 3;

  logic [N_STB-1:0] stb_lvl, stb_q, stb_rise, stb_fall;
  logic [DATA_W-1:0] in_byte, out_byte;
  logic ibf, obf, clm;
  logic data_wr_lvl, data_rd_lvl;

  mbx_host_dec #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
  ) i_dec (
    .cs_i(host_cs_i), .rd_i(host_rd_i), .wr_i(host_wr_i), .addr_i(host_addr_i),
    .out_byte_i(out_byte), .out_full_i(obf), .in_full_i(ibf), .idle_i(clm),
    .data_wr_lvl_o(data_wr_lvl), .data_rd_lvl_o(data_rd_lvl), .rdata_o(host_rdata_o)
  );

  assign stb_lvl[S_HWR] = data_wr_lvl;
  assign stb_lvl[S_HRD] = data_rd_lvl;
  assign stb_lvl[S_SWR] = sub_wr_i;
  assign stb_lvl[S_SRD] = sub_rd_i;

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    mbx_edge i_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(stb_lvl[g]),
      .q_o(stb_q[g]), .rise_o(stb_rise[g]), .fall_o(stb_fall[g])
    );
  end

  mbx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_wr_rise_i(stb_rise[S_HWR]), .host_wdata_i(host_wdata_i),
    .host_rd_fall_i(stb_fall[S_HRD]),
    .sub_wr_rise_i(stb_rise[S_SWR]), .sub_wdata_i(sub_wdata_i),
    .sub_rd_lvl_i(sub_rd_i), .sub_rd_fall_i(stb_fall[S_SRD]),
    .in_byte_o(in_byte), .out_byte_o(out_byte),
    .in_full_o(ibf), .out_full_o(obf), .idle_o(clm)
  );

  assign sub_rdata_o = in_byte;
  assign sub_irq_o   = ibf;
  assign host_irq_o  = obf;
endmodule

// File: rtl/mbx_checks.sv
module mbx_checks #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hE,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'hF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_cs_i,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_irq_o,
  input logic              sub_rd_i,
  input logic              sub_wr_i,
  input logic [DATA_W-1:0] sub_rdata_o,
  input logic              sub_irq_o,
  input logic              ibf_i,
  input logic              obf_i,
  input logic              clm_i
);
  logic hw_lvl, hr_lvl, hw_q, hr_q, sw_q, sr_q;
  logic hw_rise, hr_fall, sw_rise, sr_fall;

  assign hw_lvl  = host_cs_i & host_wr_i & (host_addr_i == DATA_OFS);
  assign hr_lvl  = host_cs_i & host_rd_i & (host_addr_i == DATA_OFS);
  assign hw_rise = hw_lvl & ~hw_q;
  assign hr_fall = ~hr_lvl & hr_q;
  assign sw_rise = sub_wr_i & ~sw_q;
  assign sr_fall = ~sub_rd_i & sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {hw_q, hr_q, sw_q, sr_q} <= '0;
    else         {hw_q, hr_q, sw_q, sr_q} <= {hw_lvl, hr_lvl, sub_wr_i, sub_rd_i};
  end

  p_stat_pad_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cs_i && host_rd_i && host_addr_i == STAT_OFS) |-> (host_rdata_o[DATA_W-1:3] == '0));

  p_wr_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rise && clm_i && !ibf_i) |=> (ibf_i && sub_rdata_o == $past(host_wdata_i)));

  p_wr_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rise && (!clm_i || ibf_i)) |=> $stable(sub_rdata_o));

  p_fetch_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_rd_i |=> !clm_i);

  p_fetch_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_fall |=> (!ibf_i && clm_i && !sub_irq_o));

  p_out_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rise |=> (obf_i && host_irq_o));

  p_out_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_fall && !sw_rise) |=> !obf_i);

  p_host_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $past(sub_wr_i));
endmodule

bind byte_mailbox mbx_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
) i_mbx_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_cs_i(host_cs_i), .host_rd_i(host_rd_i),
  .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o), .host_irq_o(host_irq_o), .sub_rd_i(sub_rd_i),
  .sub_wr_i(sub_wr_i), .sub_rdata_o(sub_rdata_o), .sub_irq_o(sub_irq_o),
  .ibf_i(ibf), .obf_i(obf), .clm_i(clm)
);

// File: tb/test_byte_mailbox.sv
module test_byte_mailbox;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_cs_i = 1'b0, host_rd_i = 1'b0, host_wr_i = 1'b0;
  logic [3:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_irq_o;
  logic       sub_rd_i = 1'b0, sub_wr_i = 1'b0;
  logic [7:0] sub_wdata_i = '0;
  logic [7:0] sub_rdata_o;
  logic       sub_irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  byte_mailbox i_byte_mailbox (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk_i);
    host_cs_i = cs; host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i);
    host_cs_i = 1'b0; host_wr_i = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    host_cs_i = 1'b1; host_rd_i = 1'b1; host_addr_i = a;
    @(negedge clk_i);
    d = host_rdata_o;
    host_cs_i = 1'b0; host_rd_i = 1'b0;
  endtask

  task automatic sub_wr(input logic [7:0] d);
    @(negedge clk_i);
    sub_wr_i = 1'b1; sub_wdata_i = d;
    @(negedge clk_i);
    sub_wr_i = 1'b0;
  endtask

  task automatic sub_rd_start();
    @(negedge clk_i);
    sub_rd_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic sub_rd_end();
    @(negedge clk_i);
    sub_rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] stat(input logic idle, input logic inf, input logic outf);
    return {5'b0, idle, inf, outf};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    host_rd(4'hF, r); chk(r, 8'h04, "R9 status");
    chk(sub_rdata_o, 8'h00, "R9 inbound byte");
    chk({6'b0, host_irq_o, sub_irq_o}, 8'h00, "R10 irqs idle");
    host_rd(4'hE, r); chk(r, 8'h00, "R9 outbound byte");
    host_rd(4'hF, r); chk(r, 8'h04, "R8 flags unchanged");

    // R11 other offsets and ignored writes
    for (int a = 0; a < 14; a++) begin
      host_rd(a[3:0], r); chk(r, 8'h00, "R11 unmapped read");
    end
    host_wr(4'hF, 8'hA5); chk(sub_rdata_o, 8'h00, "R11 write to status");
    host_wr(4'hE, 8'hC3, 1'b0); chk(sub_rdata_o, 8'h00, "R11 write with cs low");
    host_rd(4'hF, r); chk(r, 8'h04, "R11 flags untouched");

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b, o;
      b = v[7:0];
      o = ~b ^ 8'h3C;
      host_wr(4'hE, b);
      chk(sub_rdata_o, b, "R2 inbound byte");
      chk({7'b0, sub_irq_o}, 8'h01, "R10 sub irq");
      host_rd(4'hF, r); chk(r, stat(1, 1, 0), "R2 status after write");
      host_wr(4'hE, b ^ 8'h5A);
      chk(sub_rdata_o, b, "R3 blocked by full");
      sub_rd_start();
      host_rd(4'hF, r); chk(r, stat(0, 1, 0), "R4 fetch-idle low");
      sub_rd_end();
      host_rd(4'hF, r); chk(r, stat(1, 0, 0), "R5 fetch end");
      chk({7'b0, sub_irq_o}, 8'h00, "R10 sub irq clear");
      if (v % 16 == 0) begin
        sub_rd_start();
        host_wr(4'hE, b ^ 8'hFF);
        chk(sub_rdata_o, b, "R3 blocked by fetch");
        host_rd(4'hF, r); chk(r, stat(0, 0, 0), "R3 flags while fetching");
        sub_rd_end();
      end
      sub_wr(o);
      host_rd(4'hF, r); chk(r, stat(1, 0, 1), "R6 status after sub write");
      chk({7'b0, host_irq_o}, 8'h01, "R10 host irq");
      host_rd(4'hE, r); chk(r, o, "R6 outbound byte");
      host_rd(4'hF, r); chk(r, stat(1, 0, 0), "R7 outbound cleared");
      host_rd(4'hE, r); chk(r, o, "R8 stale byte");
      host_rd(4'hF, r); chk(r, stat(1, 0, 0), "R8 flags unchanged");
    end

    // R1 both full flags at once, upper bits zero
    host_wr(4'hE, 8'hFF);
    sub_wr(8'hFF);
    host_rd(4'hF, r); chk(r, 8'h07, "R1 status layout");
    sub_rd_start();
    host_rd(4'hF, r); chk(r, 8'h03, "R1 idle bit low");
    sub_rd_end();

    // R9 reset mid-run
    host_wr(4'hE, 8'h81);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    host_rd(4'hF, r); chk(r, 8'h04, "R9 status after reset");
    chk(sub_rdata_o, 8'h00, "R9 inbound cleared");
    host_rd(4'hE, r); chk(r, 8'h00, "R9 outbound cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule